// File: doc/BRIEF.md
# Payload Power Rail Sequencer and Supervisor

This block powers up the payload of a plug-in board in a fixed order and then watches the payload rails for faults. A power-on command turns on the main 12 V feed first. After that, the DC-DC converter enables are asserted one at a time in an order fixed by a parameter. Each rail must report power-good before the next rail is started. A settling delay separates consecutive enables.

Once every rail is up, the block enters supervision. In that state each rail's under-voltage and over-voltage comparator flags pass through a persistence filter. The comparator flags arrive as synchronous digital signals.

An accepted fault is recorded in a sticky register, split by rail and by type. It also raises a power-fail interrupt to the host CPU and an interrupt to the management controller.

Faults are treated by type:
- Under-voltage is a warning only, and the payload stays on.
- Over-voltage is severe.
- A rail that misses its power-good timeout during bring-up is also severe.

A severe fault gives the CPU a warning window and then powers the payload down in reverse order, with the main feed last. A power-off command runs the same reverse sequence without the warning window.

Top module: `pwr_rail_seq`

## Requirements
- R1: After reset, all enables are low and no interrupt or sticky bit is set. The main feed enable rises only on a power-on command, and it rises before any converter enable. No converter enable is ever high while the main feed is low.
- R2: Converter enables rise one per step, in the order of the `ORDER` parameter (step k enables rail `ORDER[4k+3:4k]`). The default order is rails 3,0,7,1,11,2,4,9,5,10,6,8. Consecutive rises, and the first rise after the main feed, are at least `SETTLE` cycles apart. A step starts only after the previous rail's under-voltage flag is low.
- R3: If an enabled rail keeps its under-voltage flag high, `sticky_tmo` is set exactly `tmo_lim`+1 cycles after its enable rose. No further rail is enabled, and the event is severe.
- R4: `pwr_good` rises once the last rail is good. Comparator flags are ignored before that point, so no sticky bit is set by rails that are still off during bring-up.
- R5: A comparator flag is accepted only after it has been high for `FILT` consecutive supervised cycles. A shorter pulse leaves no trace.
- R6: Any accepted fault sets `cpu_pfail` in the same cycle it is accepted, and `mgmt_irq` is high while any sticky bit is set.
- R7: An accepted under-voltage fault leaves the main feed, all converter enables and `pwr_good` unchanged.
- R8: An accepted over-voltage fault is severe. The converter enables stay on for at least `WARN_CYC` cycles after `cpu_pfail` rises, and then the reverse power-down sequence starts.
- R9: A power-off command in supervision drops `pwr_good` at once. It then removes the converter enables in reverse step order, at least `SETTLE` cycles apart, and drops the main feed last.
- R10: `sticky_uv[i]` and `sticky_ov[i]` record rail i, and `sticky_tmo` records a bring-up timeout. All of them, and `cpu_pfail` outside a shutdown, are cleared by `flt_clr`. A fault accepted in the same cycle as `flt_clr` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_on_cmd | input | 1 | Start the power-up sequence (acted on only while off) |
| pwr_off_cmd | input | 1 | Start the ordered power-down sequence |
| tmo_lim | input | TW | Power-good wait limit per step, in cycles |
| uv_flag | input | N | Per-rail under-voltage comparator flag |
| ov_flag | input | N | Per-rail over-voltage comparator flag |
| flt_clr | input | 1 | Clear the sticky fault record and the CPU interrupt |
| main_en | output | 1 | Main 12 V payload feed enable |
| conv_en | output | N | Per-rail DC-DC converter enable |
| pwr_good | output | 1 | All rails up, supervision active |
| cpu_pfail | output | 1 | Power-fail interrupt to the host CPU |
| mgmt_irq | output | 1 | Fault interrupt to the management controller |
| sticky_uv | output | N | Recorded under-voltage faults per rail |
| sticky_ov | output | N | Recorded over-voltage faults per rail |
| sticky_tmo | output | 1 | Recorded bring-up timeout |

## Verification
Two events can coincide in one cycle: the software clear of the fault record, and the filter accepting a fault that is still present. The bench provokes this by holding a rail's under-voltage flag high past the filter length, so the fault is re-accepted every cycle, and then pulsing `flt_clr`. The result is judged at the ports: the sticky bit, `cpu_pfail` and `mgmt_irq` must all still be set after the clear. Once the flag is released, a second clear must leave them all low.

// File: rtl/pwr_rail_seq.sv
module pwr_rail_seq #(
  parameter int N = 12,
  parameter int IW = $clog2(N),
  parameter logic [N*IW-1:0] ORDER = 48'h86A5942B1703,
  parameter int SETTLE = 8,
  parameter int FILT = 4,
  parameter int WARN_CYC = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_on_cmd,
  input  logic          pwr_off_cmd,
  input  logic [TW-1:0] tmo_lim,
  input  logic [N-1:0]  uv_flag,
  input  logic [N-1:0]  ov_flag,
  input  logic          flt_clr,
  output logic          main_en,
  output logic [N-1:0]  conv_en,
  output logic          pwr_good,
  output logic          cpu_pfail,
  output logic          mgmt_irq,
  output logic [N-1:0]  sticky_uv,
  output logic [N-1:0]  sticky_ov,
  output logic          sticky_tmo
);
  localparam int FW = $clog2(FILT + 1);
  localparam logic [TW-1:0] SET_L  = TW'(SETTLE - 1);
  localparam logic [TW-1:0] WARN_L = TW'(WARN_CYC - 1);
  localparam logic [FW-1:0] FL     = FW'(FILT - 1);
  localparam logic [IW-1:0] LAST   = IW'(N - 1);
  localparam logic [IW:0]   NN     = (IW + 1)'(N);

  typedef enum logic [2:0] {S_OFF, S_SETTLE, S_WAIT, S_RUN, S_WARN, S_DOWN} st_t;
  st_t st;
  logic [TW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [IW:0]   didx;
  logic [N-1:0]  uv_hit, ov_hit;

  wire [IW:0]   dm1  = didx - 1'b1;
  wire [IW-1:0] cur  = ORDER[idx*IW +: IW];
  wire [IW-1:0] dcur = ORDER[dm1[IW-1:0]*IW +: IW];
  wire run     = (st == S_RUN);
  wire tmo_hit = (st == S_WAIT) && uv_flag[cur] && (cnt == tmo_lim);
  wire sev     = |ov_hit || tmo_hit;
  wire anyf    = |uv_hit || sev;
  wire in_shut = (st == S_WARN) || (st == S_DOWN);

  assign pwr_good = run;
  assign mgmt_irq = |sticky_uv || |sticky_ov || sticky_tmo;

  for (genvar i = 0; i < N; i++) begin : g_flt
    logic [FW-1:0] uc, oc;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        uc <= '0;
        oc <= '0;
      end else begin
        uc <= (run && uv_flag[i]) ? ((uc == FL) ? uc : uc + 1'b1) : '0;
        oc <= (run && ov_flag[i]) ? ((oc == FL) ? oc : oc + 1'b1) : '0;
      end
    end
    assign uv_hit[i] = run && uv_flag[i] && (uc == FL);
    assign ov_hit[i] = run && ov_flag[i] && (oc == FL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_uv  <= '0;
      sticky_ov  <= '0;
      sticky_tmo <= 1'b0;
      cpu_pfail  <= 1'b0;
    end else begin
      sticky_uv  <= (flt_clr ? '0 : sticky_uv) | uv_hit;
      sticky_ov  <= (flt_clr ? '0 : sticky_ov) | ov_hit;
      sticky_tmo <= (flt_clr ? 1'b0 : sticky_tmo) | tmo_hit;
      cpu_pfail  <= anyf || (cpu_pfail && !(flt_clr && !in_shut));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_OFF;
      cnt     <= '0;
      idx     <= '0;
      didx    <= '0;
      main_en <= 1'b0;
      conv_en <= '0;
    end else begin
      case (st)
        S_OFF: if (pwr_on_cmd) begin
          main_en <= 1'b1;
          idx     <= '0;
          cnt     <= '0;
          st      <= S_SETTLE;
        end
        S_SETTLE: begin
          if (pwr_off_cmd) begin
            cnt <= '0; didx <= NN; st <= S_DOWN;
          end else if (cnt == SET_L) begin
            conv_en[cur] <= 1'b1;
            cnt <= '0;
            st  <= S_WAIT;
          end else cnt <= cnt + 1'b1;
        end
        S_WAIT: begin
          if (pwr_off_cmd) begin
            cnt <= '0; didx <= NN; st <= S_DOWN;
          end else if (!uv_flag[cur]) begin
            cnt <= '0;
            if (idx == LAST) st <= S_RUN;
            else begin
              idx <= idx + 1'b1;
              st  <= S_SETTLE;
            end
          end else if (cnt == tmo_lim) begin
            cnt <= '0;
            st  <= S_WARN;
          end else cnt <= cnt + 1'b1;
        end
        S_RUN: begin
          if (sev) begin
            cnt <= '0; st <= S_WARN;
          end else if (pwr_off_cmd) begin
            cnt <= '0; didx <= NN; st <= S_DOWN;
          end
        end
        S_WARN: begin
          if (cnt == WARN_L) begin
            cnt <= '0; didx <= NN; st <= S_DOWN;
          end else cnt <= cnt + 1'b1;
        end
        S_DOWN: begin
          if (cnt == SET_L) begin
            cnt <= '0;
            if (didx == '0) begin
              main_en <= 1'b0;
              st      <= S_OFF;
            end else begin
              conv_en[dcur] <= 1'b0;
              didx <= dm1;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_OFF;
      endcase
    end
  end
endmodule

// File: rtl/pwr_rail_seq_chk.sv
module pwr_rail_seq_chk #(
  parameter int N = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic         main_en,
  input logic [N-1:0] conv_en,
  input logic         pwr_good,
  input logic         flt_clr,
  input logic [N-1:0] sticky_uv,
  input logic [N-1:0] sticky_ov
);
  assert_main_first_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|conv_en) |-> main_en);

  assert_one_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(conv_en) <= $countones($past(conv_en)) + 1);

  assert_sup_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((sticky_uv != $past(sticky_uv)) && !$past(flt_clr)) |-> $past(pwr_good));

  assert_main_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(main_en) |-> ($past(conv_en) == '0));

  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_clr |=> (((sticky_uv & $past(sticky_uv)) == $past(sticky_uv)) &&
                  ((sticky_ov & $past(sticky_ov)) == $past(sticky_ov))));
endmodule

bind pwr_rail_seq pwr_rail_seq_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .main_en(main_en), .conv_en(conv_en),
  .pwr_good(pwr_good), .flt_clr(flt_clr), .sticky_uv(sticky_uv), .sticky_ov(sticky_ov)
);

// File: tb/pwr_rail_seq_tb_top.sv
`timescale 1ns/1ps
module pwr_rail_seq_tb_top;
  localparam int N = 12, SETTLE = 8, FILT = 4, WARN_CYC = 16, TW = 16;
  int ord[N] = '{3, 0, 7, 1, 11, 2, 4, 9, 5, 10, 6, 8};

  logic clk = 1'b0, rst_n = 1'b0, pwr_on_cmd = 1'b0, pwr_off_cmd = 1'b0, flt_clr = 1'b0;
  logic [TW-1:0] tmo_lim = 16'd100;
  logic [N-1:0] stuck = '0, uv_force = '0, ov_force = '0;
  logic [N-1:0] uv_flag, ov_flag, conv_en, sticky_uv, sticky_ov;
  logic main_en, pwr_good, cpu_pfail, mgmt_irq, sticky_tmo;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign uv_flag = ~conv_en | stuck | uv_force;
  assign ov_flag = ov_force;

  pwr_rail_seq #(.N(N), .SETTLE(SETTLE), .FILT(FILT), .WARN_CYC(WARN_CYC), .TW(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwr_on_cmd(pwr_on_cmd), .pwr_off_cmd(pwr_off_cmd),
    .tmo_lim(tmo_lim), .uv_flag(uv_flag), .ov_flag(ov_flag), .flt_clr(flt_clr),
    .main_en(main_en), .conv_en(conv_en), .pwr_good(pwr_good), .cpu_pfail(cpu_pfail),
    .mgmt_irq(mgmt_irq), .sticky_uv(sticky_uv), .sticky_ov(sticky_ov), .sticky_tmo(sticky_tmo));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_faults();
    flt_clr = 1'b1; tick(1); flt_clr = 1'b0; tick(1);
  endtask

  task automatic t_reset();
    tick(20);
    chk(main_en == 0 && conv_en == 0, "R1 reset enables", {main_en, conv_en}, 0);
    chk(!cpu_pfail && !mgmt_irq && !pwr_good, "R1 reset irq", {cpu_pfail, mgmt_irq, pwr_good}, 0);
    chk(sticky_uv == 0 && sticky_ov == 0 && !sticky_tmo, "R1 reset sticky", {sticky_uv, sticky_ov}, 0);
  endtask

  task automatic bring_up();
    pwr_on_cmd = 1'b1; tick(1); pwr_on_cmd = 1'b0;
    chk(main_en == 1 && conv_en == 0, "R1 main feed first", {main_en, conv_en}, 13'h1000);
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] prev = conv_en;
      int gap = 0;
      do begin tick(1); gap++; end while (conv_en == prev && gap < 500);
      chk(conv_en == (prev | (N'(1) << ord[k])), "R2 enable order", conv_en, prev | (N'(1) << ord[k]));
      chk(gap >= SETTLE, "R2 settle gap", gap, SETTLE);
    end
    tick(1);
    chk(pwr_good == 1, "R4 power good after last rail", pwr_good, 1);
    chk(sticky_uv == 0 && !cpu_pfail, "R4 no fault during bring-up", sticky_uv, 0);
  endtask

  task automatic down_seq(output int first_gap);
    first_gap = 0;
    for (int k = N - 1; k >= 0; k--) begin
      logic [N-1:0] prev = conv_en;
      int gap = 0;
      do begin tick(1); gap++; end while (conv_en == prev && gap < 500);
      if (k == N - 1) first_gap = gap;
      chk(conv_en == (prev & ~(N'(1) << ord[k])), "R9 removal order", conv_en, prev & ~(N'(1) << ord[k]));
      chk(gap >= SETTLE, "R9 removal gap", gap, SETTLE);
    end
    for (int g = 0; g < 500 && main_en; g++) tick(1);
    chk(main_en == 0 && conv_en == 0, "R9 main feed last", {main_en, conv_en}, 0);
  endtask

  task automatic t_uv_filter();
    int r = ord[6];
    uv_force[r] = 1'b1; tick(FILT - 1); uv_force[r] = 1'b0; tick(3);
    chk(sticky_uv == 0 && !cpu_pfail, "R5 short pulse filtered", sticky_uv, 0);
    uv_force[r] = 1'b1; tick(FILT);
    chk(sticky_uv == (N'(1) << r), "R10 uv rail recorded", sticky_uv, N'(1) << r);
    chk(cpu_pfail && mgmt_irq, "R6 interrupts on uv", {cpu_pfail, mgmt_irq}, 3);
    tick(30);
    chk(main_en && conv_en == '1 && pwr_good, "R7 uv keeps payload on", {main_en, conv_en, pwr_good}, 14'h3fff);
  endtask

  task automatic t_clear_race();
    int r = ord[6];
    flt_clr = 1'b1; tick(1); flt_clr = 1'b0;
    chk(sticky_uv == (N'(1) << r), "R10 set wins over clear", sticky_uv, N'(1) << r);
    chk(cpu_pfail && mgmt_irq, "R10 irq kept on race", {cpu_pfail, mgmt_irq}, 3);
    uv_force[r] = 1'b0; tick(1);
    clear_faults();
    chk(sticky_uv == 0 && !cpu_pfail && !mgmt_irq, "R10 clear", {sticky_uv, cpu_pfail, mgmt_irq}, 0);
  endtask

  task automatic t_poweroff();
    int fg;
    pwr_off_cmd = 1'b1; tick(1); pwr_off_cmd = 1'b0;
    chk(pwr_good == 0, "R9 power good drops", pwr_good, 0);
    down_seq(fg);
    chk(!cpu_pfail && !mgmt_irq, "R9 no fault on command", {cpu_pfail, mgmt_irq}, 0);
  endtask

  task automatic t_ov_severe();
    int c = 0, fg;
    ov_force[5] = 1'b1;
    do begin tick(1); c++; end while (!cpu_pfail && c < 100);
    chk(c == FILT, "R5 ov accepted after filter", c, FILT);
    chk(sticky_ov == (N'(1) << 5) && mgmt_irq, "R6 ov recorded", sticky_ov, N'(1) << 5);
    chk(conv_en == '1 && main_en, "R8 rails on at warning", conv_en, 12'hfff);
    down_seq(fg);
    chk(fg >= WARN_CYC, "R8 warning window", fg, WARN_CYC);
    ov_force[5] = 1'b0;
    clear_faults();
  endtask

  task automatic t_timeout();
    int r = ord[3], c = 0, fg;
    tmo_lim = 16'd20;
    stuck[r] = 1'b1;
    pwr_on_cmd = 1'b1; tick(1); pwr_on_cmd = 1'b0;
    for (int g = 0; g < 500 && !conv_en[r]; g++) tick(1);
    do begin tick(1); c++; end while (!sticky_tmo && c < 500);
    chk(c == 21, "R3 timeout cycle", c, 21);
    chk(cpu_pfail && mgmt_irq, "R6 interrupts on timeout", {cpu_pfail, mgmt_irq}, 3);
    chk(conv_en[ord[4]] == 0, "R3 next rail not enabled", conv_en[ord[4]], 0);
    for (int g = 0; g < 1000 && main_en; g++) begin
      tick(1);
      if (conv_en[ord[4]]) begin chk(0, "R3 next rail enabled", 1, 0); break; end
    end
    chk(main_en == 0 && conv_en == 0, "R3 severe shutdown", {main_en, conv_en}, 0);
    stuck[r] = 1'b0;
    clear_faults();
  endtask

  initial begin
    tick(5); rst_n = 1'b1;
    t_reset();
    bring_up();
    t_uv_filter();
    t_clear_race();
    t_poweroff();
    bring_up();
    t_ov_severe();
    t_timeout();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule